// File: doc/BRIEF.md
# Pulse Channel Window Comparator

This block forms the output of one pulse-width channel. A shared phase counter sweeps a 16-bit fraction of the pulse period. The channel compares that phase with its own rising-edge offset and its own pulse length. The output goes high at the offset and stays high for the pulse length. When the pulse runs past the end of the period, it continues from the start of the next one.

The resolution input selects how many of the top bits of the phase, the offset and the length are significant. The low bits of all three are ignored. The offset and the length are copied into shadow registers only when the significant phase bits are all zero, so a value written in the middle of a period cannot cut a pulse short or lengthen it. A channel enable forces the idle level. An invert bit makes the channel active-low.

The output is registered. It reflects the inputs that were present at the previous rising clock edge. Reset is synchronous and active-high.

Top module: `pwm_edge_cmp`

## Requirements
- R1: While `rst` is high at a clock edge, `pulse_o` becomes 0 and both shadow values become 0. After reset the output therefore stays at its idle level until the first period boundary.
- R2: `pulse_o` is registered. After each rising edge it shows the result computed from the inputs and shadow values sampled at that edge.
- R3: Let P, D and U be the phase, the shadowed offset and the shadowed length, each with only its top `res_i`+1 bits kept. The pulse is active exactly when (P − D) mod 2^16 < U. The pulse therefore rises at P = D.
- R4: When D + U exceeds 2^16, the active window continues at phase 0. The output stays active for P < (D + U) mod 2^16.
- R5: Bits of `phase_i`, `delay_i` and `duty_i` below the top `res_i`+1 bits have no effect on `pulse_o`.
- R6: When the shadowed length is 0 after masking, the output holds its idle level for the whole period.
- R7: When `enable_i` is 0 at an edge, `pulse_o` takes the idle level `invert_i` after that edge.
- R8: When `invert_i` is 1, `pulse_o` is the complement of the value it would have with `invert_i` at 0.
- R9: A period boundary is an edge at which the masked phase is 0. At a boundary the masked `delay_i` and `duty_i` are captured and used in that same edge's comparison. At any other edge, changes to `delay_i` and `duty_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | PHASE_W (16) | Shared period phase, as a fraction of the period |
| res_i | input | RES_W (4) | Resolution: the number of significant top bits, minus 1 |
| delay_i | input | PHASE_W (16) | Phase offset of the rising edge |
| duty_i | input | PHASE_W (16) | Pulse length, as a fraction of the period |
| enable_i | input | 1 | Channel enable |
| invert_i | input | 1 | 1 makes the output active-low |
| pulse_o | output | 1 | Registered channel output |

## Verification
Two functions can act in the same cycle. At a period boundary the shadow values are reloaded, and in that same cycle the window comparison must already use the reloaded values. The bench provokes this by presenting a new offset and length together with phase 0. In one case the new offset places the rising edge exactly at 0. In another the new length is 0, or a wrapped window from the old values would still be active at 0. Both outputs are judged against a bench model that updates its own shadow copy before it evaluates the comparison. A second collision is a value change in the middle of a period that meets a pulse edge. The bench judges it against the held values.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int unsigned PHASE_W_DEF = 16;
  localparam int unsigned RES_W_DEF   = 4;

  typedef struct packed {
    logic [PHASE_W_DEF-1:0] delay;
    logic [PHASE_W_DEF-1:0] duty;
  } edge_cfg_t;
endpackage

// File: rtl/pwm_res_mask.sv
module pwm_res_mask #(
  parameter int unsigned W  = 16,
  parameter int unsigned RW = 4
) (
  input  logic [RW-1:0] res,
  input  logic [W-1:0]  val,
  output logic [W-1:0]  masked
);
  // Bit i is kept when it is among the top (res+1) bits.
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned THR = W - 1 - i;
    assign masked[i] = val[i] & (32'(res) >= THR);
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned W = PHASE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] delay_new,
  input  logic [W-1:0] duty_new,
  output logic [W-1:0] delay_q,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] delay_act,
  output logic [W-1:0] duty_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= '0;
      duty_q  <= '0;
    end else if (load) begin
      delay_q <= delay_new;
      duty_q  <= duty_new;
    end
  end

  // At a boundary the fresh values already govern this edge.
  always_comb begin
    delay_act = load ? delay_new : delay_q;
    duty_act  = load ? duty_new  : duty_q;
  end
endmodule

// File: rtl/pwm_window_cmp.sv
module pwm_window_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] phase_m,
  input  logic [W-1:0] delay_act,
  input  logic [W-1:0] duty_act,
  input  logic         enable,
  input  logic         invert,
  output logic         pulse_q
);
  logic [W-1:0] offset;
  logic         in_window;
  logic         level;

  always_comb begin
    offset    = phase_m - delay_act;   // modulo 2^W wrap
    in_window = offset < duty_act;
    level     = enable ? (in_window ^ invert) : invert;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= level;
  end
endmodule

// File: rtl/pwm_edge_cmp.sv
module pwm_edge_cmp
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned PHASE_W = PHASE_W_DEF,
  parameter int unsigned RES_W   = RES_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic [PHASE_W-1:0] delay_i,
  input  logic [PHASE_W-1:0] duty_i,
  input  logic               enable_i,
  input  logic               invert_i,
  output logic               pulse_o
);
  logic [PHASE_W-1:0] phase_m, delay_m, duty_m;
  logic [PHASE_W-1:0] delay_q, duty_q, delay_act, duty_act;
  logic               boundary;

  pwm_res_mask #(.W(PHASE_W), .RW(RES_W)) u_mask_phase (
    .res(res_i), .val(phase_i), .masked(phase_m));
  pwm_res_mask #(.W(PHASE_W), .RW(RES_W)) u_mask_delay (
    .res(res_i), .val(delay_i), .masked(delay_m));
  pwm_res_mask #(.W(PHASE_W), .RW(RES_W)) u_mask_duty (
    .res(res_i), .val(duty_i), .masked(duty_m));

  assign boundary = (phase_m == '0);

  pwm_shadow_regs #(.W(PHASE_W)) u_shadow (
    .clk(clk), .rst(rst), .load(boundary),
    .delay_new(delay_m), .duty_new(duty_m),
    .delay_q(delay_q), .duty_q(duty_q),
    .delay_act(delay_act), .duty_act(duty_act));

  pwm_window_cmp #(.W(PHASE_W)) u_cmp (
    .clk(clk), .rst(rst), .phase_m(phase_m),
    .delay_act(delay_act), .duty_act(duty_act),
    .enable(enable_i), .invert(invert_i), .pulse_q(pulse_o));
endmodule

// File: rtl/pwm_edge_cmp_chk.sv
module pwm_edge_cmp_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         enable_i,
  input logic         invert_i,
  input logic         pulse_o,
  input logic         boundary,
  input logic [W-1:0] phase_m,
  input logic [W-1:0] delay_act,
  input logic [W-1:0] duty_act,
  input logic [W-1:0] delay_q,
  input logic [W-1:0] duty_q
);
  // R7
  disabled_level_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> pulse_o == $past(invert_i));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && duty_act == '0) |=> pulse_o == $past(invert_i));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(duty_q) && $stable(delay_q)));

  // R3
  rising_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && duty_act != '0 && phase_m == delay_act)
      |=> pulse_o != $past(invert_i));
endmodule

bind pwm_edge_cmp pwm_edge_cmp_chk #(.W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .enable_i(enable_i), .invert_i(invert_i),
  .pulse_o(pulse_o), .boundary(boundary), .phase_m(phase_m),
  .delay_act(delay_act), .duty_act(duty_act),
  .delay_q(delay_q), .duty_q(duty_q));

// File: tb/sim_pwm_edge_cmp.sv
module sim_pwm_edge_cmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] phase_i = '0, delay_i = '0, duty_i = '0;
  logic [3:0]  res_i = '0;
  logic        enable_i = 1'b0, invert_i = 1'b0;
  logic        pulse_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_delay = '0, m_duty = '0;

  always #2.5 clk = ~clk;

  pwm_edge_cmp u0 (.clk(clk), .rst(rst), .phase_i(phase_i), .res_i(res_i),
    .delay_i(delay_i), .duty_i(duty_i), .enable_i(enable_i),
    .invert_i(invert_i), .pulse_o(pulse_o));

  function automatic logic [15:0] msk(input logic [3:0] r);
    return 16'hFFFF << (15 - r);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pulse_o=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: apply inputs, clock, update the model, compare.
  task automatic step(input string tag, input logic [15:0] ph, input logic [3:0] r,
                      input logic [15:0] dl, input logic [15:0] dt,
                      input logic en, input logic inv);
    logic [15:0] pm, diff;
    logic exp;
    phase_i = ph; res_i = r; delay_i = dl; duty_i = dt;
    enable_i = en; invert_i = inv;
    pm = ph & msk(r);
    if (pm == 16'h0) begin
      m_delay = dl & msk(r);
      m_duty  = dt & msk(r);
    end
    diff = pm - m_delay;
    exp  = en ? ((diff < m_duty) ^ inv) : inv;
    @(posedge clk); #1;
    check(tag, pulse_o, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", pulse_o, 1'b0);
    rst = 1'b0;
    // R1: shadow values are zero, so the output idles before any boundary.
    step("R1", 16'h4000, 4'd2, 16'h0000, 16'hE000, 1'b1, 1'b0);
    // R2: registered result after a boundary.
    step("R2", 16'h0000, 4'd2, 16'h0000, 16'h6000, 1'b1, 1'b0);

    // Near-exhaustive sweep for resolutions 0..2.
    for (int r = 0; r < 3; r++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int d = 0; d < (2 << r); d++) begin
          for (int u = 0; u < (2 << r); u++) begin
            for (int p = 0; p < (2 << r); p++) begin
              logic [15:0] dl, dt, ph;
              string tag;
              dl = 16'(d) << (15 - r);
              dt = 16'(u) << (15 - r);
              ph = 16'(p) << (15 - r);
              if (u == 0) tag = "R6";
              else if (p < d) tag = "R4";
              else if (inv == 1) tag = "R8";
              else tag = "R3";
              step(tag, ph, 4'(r), dl, dt, 1'b1, 1'(inv));
            end
          end
        end
      end
    end

    // R5: noise in the low bits must change nothing.
    for (int p = 0; p < 8; p++) begin
      logic [15:0] n;
      n = 16'h1FFF & (16'h0ACE * 16'(p + 3));
      step("R5", (16'(p) << 13) | n, 4'd2, 16'hA000 | ~n & 16'h1FFF,
           16'hC000 | n, 1'b1, 1'b0);
    end

    // R7: disabled channel idles at the invert level.
    for (int p = 0; p < 8; p++)
      step("R7", 16'(p) << 13, 4'd2, 16'h2000, 16'h8000, 1'b0, 1'(p & 1));

    // R9: changes in mid-period are ignored until the next boundary.
    step("R9", 16'h0000, 4'd2, 16'h2000, 16'h4000, 1'b1, 1'b0);
    for (int p = 1; p < 8; p++)
      step("R9", 16'(p) << 13, 4'd2, 16'hC000, 16'h2000, 1'b1, 1'b0);
    // R9: the same-edge load at the boundary uses the fresh values (zero length).
    step("R9", 16'h0000, 4'd2, 16'h0000, 16'h0000, 1'b1, 1'b0);
    // R4/R9: a wrapped window from the old values meets a fresh load at phase 0.
    step("R4", 16'h0000, 4'd2, 16'hC000, 16'h8000, 1'b1, 1'b0);
    step("R4", 16'hE000, 4'd2, 16'h2000, 16'h2000, 1'b1, 1'b0);
    step("R9", 16'h0000, 4'd2, 16'h2000, 16'h2000, 1'b1, 1'b0);

    // R3: full resolution, window at a single-step level.
    step("R3", 16'h0000, 4'd15, 16'h0005, 16'h0003, 1'b1, 1'b0);
    for (int p = 1; p < 12; p++)
      step("R3", 16'(p), 4'd15, 16'h0005, 16'h0003, 1'b1, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule